// File: doc/BRIEF.md
# SAR ADC Serial Readout Controller

This block is the host side of a 16-bit successive-approximation converter that is read over a three-wire link: a convert strobe, a serial clock and a single data return line. The converter's own data input is tied high, so each conversion is selected by the convert strobe alone. A sample request, or a periodic tick from a timer, makes the controller raise the convert strobe. It holds the strobe high for a programmed number of system clocks while the converter works, then drops it. The converter puts its most significant bit on the data line as soon as the strobe falls. After that, every falling edge of the serial clock moves the next bit out.

The controller captures the first bit one system clock after the strobe falls. It then runs sixteen serial clock pulses and captures a further bit in the last system clock of the low phase that follows each of the first fifteen falling edges. The assembled word is presented with a one-cycle valid strobe. A busy flag covers the span from conversion start to data delivery. A minimum spacing between conversion starts is enforced. A request that arrives while the controller cannot start is held in a one-deep pending flag.

The state machine has six states. In ST_IDLE it waits for a request. ST_CONV holds the strobe high. ST_MSB is the single cycle after the strobe falls. ST_SCK_HI and ST_SCK_LO form the two halves of a serial clock pulse. ST_DONE is the cycle that carries the valid strobe. The transitions are:
- ST_IDLE to ST_CONV when a request or the pending flag is present and the spacing timer has expired.
- ST_CONV to ST_MSB when the conversion wait ends.
- ST_MSB to ST_SCK_HI unconditionally.
- ST_SCK_HI to ST_SCK_LO at the end of a high half period, except after the sixteenth pulse.
- ST_SCK_HI to ST_DONE at the end of the sixteenth high half period.
- ST_SCK_LO to ST_SCK_HI at the end of a low half period.
- ST_DONE to ST_IDLE unconditionally.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, adc_cnv, adc_sck, busy and sample_valid are 0 and sample_data is all zeros.
- R2: A 1 on start_req or tick, sampled in idle with the spacing timer expired, raises adc_cnv in the next cycle. busy is 1 whenever adc_cnv is 1.
- R3: adc_cnv stays high for exactly CONV_CYCLES system clock cycles per conversion. adc_sck stays 0 while adc_cnv is 1.
- R4: Each readout produces exactly 16 adc_sck pulses. Each pulse is high for SCK_DIV cycles, with SCK_DIV low cycles between pulses. adc_sck is 0 outside a readout.
- R5: The first bit is taken from adc_sdo one cycle after adc_cnv falls and becomes sample_data bit 15. The bits that follow the first 15 adc_sck falling edges fill bits 14 down to 0, in order.
- R6: sample_valid is 1 for exactly one cycle, the cycle after the 16th adc_sck falling edge. busy is 0 in that cycle. sample_data keeps its value until the next sample_valid.
- R7: Two rising edges of adc_cnv are never closer than CYCLE_MIN cycles. With default parameters and a request waiting, they are exactly CYCLE_MIN apart.
- R8: Any number of requests that arrive while a cycle is in progress start exactly one further conversion.
- R9: A reset during a readout drops adc_cnv, adc_sck and busy in the next cycle. It produces no sample_valid, discards a pending request and lets a new request start at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Single-cycle sample request |
| tick | input | 1 | Periodic sample request from a timer |
| adc_sdo | input | 1 | Serial data returned by the converter |
| adc_cnv | output | 1 | Convert strobe; high while the converter works |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| sample_data | output | DATA_W | Last captured sample, MSB first on the wire |
| sample_valid | output | 1 | One-cycle strobe for a new sample_data |
| busy | output | 1 | High from conversion start until the word is ready |

## Verification
The properties assume that reset is synchronous and that any fall of adc_cnv or adc_sck caused by reset is exempt from the width checks. The checker follows the cycle after reset for this purpose. Because the checker cannot observe the converter, it does not model adc_sdo timing. The bench's converter model changes adc_sdo only after a falling edge of adc_cnv or adc_sck, never close to a system clock edge. The bench drives inputs two time units after the rising clock edge and checks outputs on the falling edge. Requests are separated by enough idle cycles, except in the directed tests that deliberately overlap them.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    // Controller sequence states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CONV   = 3'd1,
        ST_MSB    = 3'd2,
        ST_SCK_HI = 3'd3,
        ST_SCK_LO = 3'd4,
        ST_DONE   = 3'd5
    } rd_state_t;

endpackage

// File: rtl/sar_rd_phase_cnt.sv
// Counts cycles spent in one phase; done once LIMIT cycles have elapsed.
module sar_rd_phase_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_rd_gap_timer.sv
// Enforces the minimum spacing between convert strobe rising edges.
module sar_rd_gap_timer #(
    parameter int CYCLE_MIN = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ok
);
    localparam int GW = $clog2(CYCLE_MIN + 1);

    logic [GW-1:0] cnt;

    assign ok = (cnt >= GW'(CYCLE_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= GW'(CYCLE_MIN);
        end else if (start) begin
            cnt <= GW'(1);
        end else if (!ok) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_rd_shift.sv
// Serial-in shift register; the first captured bit ends up as the MSB.
module sar_rd_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              sdi,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (cap) begin
            word <= {word[DATA_W-2:0], sdi};
        end
    end

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SCK_DIV     = 2,
    parameter int CONV_CYCLES = 50,
    parameter int CYCLE_MIN   = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              tick,
    input  logic              adc_sdo,
    output logic              adc_cnv,
    output logic              adc_sck,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              busy
);
    localparam int FW = $clog2(DATA_W + 1);

    rd_state_t         state, state_nx;
    logic              req, pend, gap_ok, go;
    logic              conv_done, half_done, last_fall;
    logic              phase_clr, conv_en, half_en;
    logic              conv_start, cap, load_res, fall_step;
    logic [FW-1:0]     fall_cnt;
    logic [DATA_W-1:0] shift_word;

    assign req       = start_req | tick;
    assign go        = (req | pend) & gap_ok;
    assign last_fall = (fall_cnt == FW'(DATA_W - 1));
    assign phase_clr = (state_nx != state);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (go)        state_nx = ST_CONV;
            ST_CONV:   if (conv_done) state_nx = ST_MSB;
            ST_MSB:                   state_nx = ST_SCK_HI;
            ST_SCK_HI: if (half_done) state_nx = last_fall ? ST_DONE : ST_SCK_LO;
            ST_SCK_LO: if (half_done) state_nx = ST_SCK_HI;
            ST_DONE:                  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        adc_cnv      = 1'b0;
        adc_sck      = 1'b0;
        busy         = 1'b0;
        sample_valid = 1'b0;
        conv_en      = 1'b0;
        half_en      = 1'b0;
        conv_start   = 1'b0;
        cap          = 1'b0;
        load_res     = 1'b0;
        fall_step    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                conv_start = go;
            end
            ST_CONV: begin
                adc_cnv = 1'b1;
                busy    = 1'b1;
                conv_en = 1'b1;
            end
            ST_MSB: begin
                busy = 1'b1;
                cap  = 1'b1;
            end
            ST_SCK_HI: begin
                adc_sck   = 1'b1;
                busy      = 1'b1;
                half_en   = 1'b1;
                fall_step = half_done;
                load_res  = half_done & last_fall;
            end
            ST_SCK_LO: begin
                busy    = 1'b1;
                half_en = 1'b1;
                cap     = half_done;
            end
            ST_DONE: begin
                sample_valid = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // Count of serial clock falling edges in this readout
    always_ff @(posedge clk) begin
        if (rst || conv_start) begin
            fall_cnt <= '0;
        end else if (fall_step) begin
            fall_cnt <= fall_cnt + 1'b1;
        end
    end

    // One-deep pending request
    always_ff @(posedge clk) begin
        if (rst || conv_start) begin
            pend <= 1'b0;
        end else if (req) begin
            pend <= 1'b1;
        end
    end

    // Result register, held until the next readout finishes
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_data <= '0;
        end else if (load_res) begin
            sample_data <= shift_word;
        end
    end

    sar_rd_phase_cnt #(.LIMIT(CONV_CYCLES)) u_conv_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase_clr),
        .en   (conv_en),
        .done (conv_done)
    );

    sar_rd_phase_cnt #(.LIMIT(SCK_DIV)) u_half_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase_clr),
        .en   (half_en),
        .done (half_done)
    );

    sar_rd_gap_timer #(.CYCLE_MIN(CYCLE_MIN)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .start (conv_start),
        .ok    (gap_ok)
    );

    sar_rd_shift #(.DATA_W(DATA_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .sdi  (adc_sdo),
        .word (shift_word)
    );

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
    parameter int DATA_W      = 16,
    parameter int SCK_DIV     = 2,
    parameter int CONV_CYCLES = 50,
    parameter int CYCLE_MIN   = 120
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_cnv,
    input logic              adc_sck,
    input logic              busy,
    input logic              sample_valid,
    input logic [DATA_W-1:0] sample_data
);
    localparam int HW = $clog2(CONV_CYCLES + 2);
    localparam int SW = $clog2(SCK_DIV + 2);
    localparam int GW = $clog2(CYCLE_MIN + 2);
    localparam int PW = $clog2(DATA_W + 2);

    logic          cnv_q, sck_q, rst_q;
    logic [HW-1:0] hi_len;
    logic [SW-1:0] sck_run;
    logic [GW-1:0] gap;
    logic [PW-1:0] pulses;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            cnv_q   <= 1'b0;
            sck_q   <= 1'b0;
            hi_len  <= '0;
            sck_run <= '0;
            gap     <= GW'(CYCLE_MIN);
            pulses  <= '0;
        end else begin
            cnv_q   <= adc_cnv;
            sck_q   <= adc_sck;
            hi_len  <= adc_cnv ? hi_len + 1'b1 : '0;
            sck_run <= adc_sck ? sck_run + 1'b1 : '0;
            if (adc_cnv && !cnv_q) begin
                gap <= GW'(1);
            end else if (gap < GW'(CYCLE_MIN)) begin
                gap <= gap + 1'b1;
            end
            if (adc_cnv) begin
                pulses <= '0;
            end else if (adc_sck && !sck_q) begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    AST_BUSY_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> busy); // R2
    AST_SCK_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> !adc_sck); // R3
    AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!adc_cnv && cnv_q && !rst_q) |-> (hi_len == HW'(CONV_CYCLES))); // R3
    AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!adc_sck && sck_q && !rst_q) |-> (sck_run == SW'(SCK_DIV))); // R4
    AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (pulses == PW'(DATA_W))); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid); // R6
    AST_VALID_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (!busy && !adc_cnv && !adc_sck)); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !rst_q) |-> $stable(sample_data)); // R6
    AST_CNV_SPACING: assert property (@(posedge clk) disable iff (rst)
        (adc_cnv && !cnv_q) |-> (gap >= GW'(CYCLE_MIN))); // R7

endmodule

bind sar_rd_ctrl sar_rd_checker #(
    .DATA_W      (DATA_W),
    .SCK_DIV     (SCK_DIV),
    .CONV_CYCLES (CONV_CYCLES),
    .CYCLE_MIN   (CYCLE_MIN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_cnv      (adc_cnv),
    .adc_sck      (adc_sck),
    .busy         (busy),
    .sample_valid (sample_valid),
    .sample_data  (sample_data)
);

// File: tb/sar_rd_ctrl_test.sv
`timescale 1ns/1ps
module sar_rd_ctrl_test;
    localparam int DATA_W      = 16;
    localparam int SCK_DIV     = 2;
    localparam int CONV_CYCLES = 50;
    localparam int CYCLE_MIN   = 120;
    localparam int NVEC        = 6;

    // {sample word, 1 = request through tick, 0 = through start_req}
    localparam logic [16:0] VECS [NVEC] = '{
        {16'hA5C3, 1'b0}, {16'h0000, 1'b1}, {16'hFFFF, 1'b0},
        {16'h8001, 1'b1}, {16'h7FFE, 1'b0}, {16'h1234, 1'b1}
    };

    logic clk = 1'b0;
    logic rst, start_req, tick;
    logic adc_cnv, adc_sck, sample_valid, busy;
    logic [DATA_W-1:0] sample_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Converter model
    logic [15:0] mdl_word = 16'h0000;
    int          mdl_idx  = 0;
    bit          mdl_act  = 1'b0;
    wire         adc_sdo  = mdl_act ? mdl_word[mdl_idx] : 1'b0;

    always #5 clk = ~clk;

    sar_rd_ctrl #(
        .DATA_W(DATA_W), .SCK_DIV(SCK_DIV),
        .CONV_CYCLES(CONV_CYCLES), .CYCLE_MIN(CYCLE_MIN)
    ) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .tick(tick),
        .adc_sdo(adc_sdo), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
        .sample_data(sample_data), .sample_valid(sample_valid), .busy(busy)
    );

    always @(negedge adc_cnv) begin
        #1;
        mdl_idx = 15;
        mdl_act = 1'b1;
    end
    always @(posedge adc_cnv) mdl_act = 1'b0;
    always @(negedge adc_sck) begin
        #1;
        if (mdl_act) begin
            if (mdl_idx == 0) mdl_act = 1'b0;
            else              mdl_idx = mdl_idx - 1;
        end
    end

    // Line monitor, sampled on the falling clock edge
    int cyc = 0;
    int conv_cnt = 0, valid_cnt = 0, dbl_valid = 0, overlap = 0, bad_w = 0;
    int last_rise = -1, last_gap = 0, hi_run = 0, last_hi = 0;
    int pulse_cnt = 0, sck_run = 0, lo_run = 0;
    bit cnv_p = 0, sck_p = 0, val_p = 0, rst_p = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (adc_cnv && !cnv_p) begin
            conv_cnt++;
            if (last_rise >= 0) last_gap = cyc - last_rise;
            last_rise = cyc;
            hi_run = 0;
            pulse_cnt = 0;
        end
        if (adc_cnv) hi_run++;
        if (!adc_cnv && cnv_p && !rst_p) last_hi = hi_run;
        if (adc_cnv && adc_sck) overlap++;
        if (adc_sck && !sck_p) begin
            if (pulse_cnt >= 1 && lo_run != SCK_DIV) bad_w++;
            pulse_cnt++;
            sck_run = 0;
        end
        if (adc_sck) sck_run++;
        if (!adc_sck && sck_p) begin
            if (!rst_p && sck_run != SCK_DIV) bad_w++;
            lo_run = 0;
        end
        if (!adc_sck) lo_run++;
        if (sample_valid) valid_cnt++;
        if (sample_valid && val_p) dbl_valid++;
        cnv_p = adc_cnv;
        sck_p = adc_sck;
        val_p = sample_valid;
        rst_p = rst;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_step();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_req(input bit use_tick);
        drive_step();
        if (use_tick) tick = 1'b1; else start_req = 1'b1;
        drive_step();
        tick = 1'b0;
        start_req = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (sample_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        int base_conv, base_valid;
        rst = 1'b1;
        start_req = 1'b0;
        tick = 1'b0;
        idle_cycles(3);
        // R1: reset state
        chk("R1 cnv in reset", adc_cnv, 0);
        chk("R1 sck in reset", adc_sck, 0);
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", sample_valid, 0);
        chk("R1 data in reset", sample_data, 0);
        drive_step();
        rst = 1'b0;
        idle_cycles(2);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            mdl_word = VECS[i][16:1];
            bad_w = 0;
            overlap = 0;
            pulse_req(VECS[i][0]);
            @(negedge clk);
            chk("R2 cnv raised after request", adc_cnv, 1);
            chk("R2 busy during conversion", busy, 1);
            wait_valid(seen);
            chk("R6 valid seen", seen, 1);
            chk("R5 sample word", sample_data, VECS[i][16:1]);
            chk("R6 busy low with valid", busy, 0);
            chk("R3 cnv high width", last_hi, CONV_CYCLES);
            chk("R3 sck quiet while cnv high", overlap, 0);
            chk("R4 pulse count", pulse_cnt, 16);
            chk("R4 pulse widths", bad_w, 0);
            @(negedge clk);
            chk("R6 valid one cycle", sample_valid, 0);
            idle_cycles(20);
            chk("R6 data held", sample_data, VECS[i][16:1]);
            chk("R4 sck idle low", adc_sck, 0);
            idle_cycles(70);
        end
        chk("R6 no double valid", dbl_valid, 0);

        // R7 and R8: requests during a cycle collapse into one follow-up
        base_conv = conv_cnt;
        mdl_word = 16'hC0DE;
        pulse_req(1'b0);
        idle_cycles(5);
        pulse_req(1'b0);
        idle_cycles(10);
        pulse_req(1'b1);
        wait_valid(seen);
        chk("R8 first word", sample_data, 16'hC0DE);
        mdl_word = 16'h3A5F;
        wait_valid(seen);
        chk("R8 follow-up valid", seen, 1);
        chk("R8 follow-up word", sample_data, 16'h3A5F);
        chk("R7 start spacing", last_gap, CYCLE_MIN);
        idle_cycles(300);
        chk("R8 one extra conversion", conv_cnt - base_conv, 2);

        // R9: reset during readout
        mdl_word = 16'h5555;
        pulse_req(1'b0);
        while (pulse_cnt < 3) @(negedge clk);
        pulse_req(1'b1);
        while (pulse_cnt < 5) @(negedge clk);
        base_conv = conv_cnt;
        base_valid = valid_cnt;
        drive_step();
        rst = 1'b1;
        drive_step();
        rst = 1'b0;
        @(negedge clk);
        chk("R9 cnv low after reset", adc_cnv, 0);
        chk("R9 sck low after reset", adc_sck, 0);
        chk("R9 busy low after reset", busy, 0);
        chk("R1 data cleared by reset", sample_data, 0);
        idle_cycles(200);
        chk("R9 no valid after abort", valid_cnt - base_valid, 0);
        chk("R9 pending discarded", conv_cnt - base_conv, 0);
        mdl_word = 16'h9E01;
        pulse_req(1'b0);
        @(negedge clk);
        chk("R9 restart at once", adc_cnv, 1);
        wait_valid(seen);
        chk("R9 word after restart", sample_data, 16'h9E01);
        idle_cycles(5);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule